// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block is a synchronous front end for an external asynchronous low-power SRAM of 256K words by 16 bits. It accepts one request at a time through a valid/ready handshake. A request carries an 18-bit word address, a 2-bit byte-lane mask and write data. The block then runs the active-low strobe sequence on the memory pins: chip enable, write enable, output enable, and the upper and lower byte enables. The shared data bus is split into an output value, a drive-enable and an input value, so a pad or a bench can resolve it.

Every phase of an access lasts a whole number of system-clock cycles, and parameters set those counts. A read holds the output strobes for `T_RD` cycles, captures the data and returns it with a single-cycle `rd_valid` pulse. A write drives its data for `T_DS` cycles before the write-enable pulse and keeps driving it for `T_DH` cycles after the pulse. The write-enable pulse itself lasts `T_WP` cycles. After a write the strobes rest for `T_GAP` cycles, and after a read the bus is left idle for `T_TURN` cycles. Between accesses chip enable stays high, so the memory is in standby.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, and whenever `req_ready` is high, `sram_ce_n`, `sram_we_n`, `sram_oe_n`, `sram_ub_n` and `sram_lb_n` are all 1, `sram_dq_oe` is 0 and `rd_valid` is 0.
- R2: A read holds `sram_ce_n` and `sram_oe_n` at 0 and `sram_we_n` at 1 for exactly `T_RD` consecutive cycles.
- R3: During an access, `sram_ub_n` equals the inverse of mask bit 1 and `sram_lb_n` equals the inverse of mask bit 0. Bit 1 selects data bits 15:8 and bit 0 selects bits 7:0.
- R4: `sram_dq_oe` is never 1 while `sram_oe_n` is 0, and `sram_oe_n` stays 1 for the whole of a write.
- R5: A write pulses `sram_we_n` low for exactly `T_WP` consecutive cycles. `sram_we_n` is low only while `sram_ce_n` is low.
- R6: `sram_addr` keeps the accepted address and does not change while `sram_ce_n` stays low.
- R7: During a write, `sram_dq_o` carries the request's write data. `sram_dq_oe` is 1 for exactly `T_DS` cycles before `sram_we_n` falls. After `sram_we_n` rises, `sram_dq_oe` stays 1 for exactly `T_DH` cycles with `sram_ce_n` still low.
- R8: After a write, `sram_ce_n` and `sram_we_n` stay high for `T_GAP` cycles before `req_ready` returns. Consecutive write pulses are therefore separated by more than one high cycle.
- R9: After a read, `sram_ce_n` and `sram_oe_n` stay high and `sram_dq_oe` stays 0 for `T_TURN` cycles before `req_ready` returns.
- R10: `rd_valid` is 1 for exactly one cycle, starting `T_RD + 1` cycles after the accepting edge. With it, `rd_data` holds the memory data sampled on the last output-enable cycle, and byte lanes that the mask leaves out read as 0.
- R11: A write updates only the byte lanes its mask selects. A later read returns the other lanes unchanged.
- R12: `req_ready` falls on the accepting edge and stays low until the access and its recovery phase have finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_be | input | 2 | Byte-lane mask, bit 1 upper, bit 0 lower, active high |
| req_wdata | input | 16 | Write data |
| rd_data | output | 16 | Captured read data, unselected lanes zero |
| rd_valid | output | 1 | One-cycle read-data strobe |
| sram_addr | output | 18 | Memory address |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_ub_n | output | 1 | Upper byte enable, active low |
| sram_lb_n | output | 1 | Lower byte enable, active low |
| sram_dq_o | output | 16 | Data driven toward the memory |
| sram_dq_oe | output | 1 | Drive enable for `sram_dq_o` |
| sram_dq_i | input | 16 | Data returned by the memory |

## Verification
The accepting edge is cycle 0. The bench samples at each falling edge and numbers the samples from 1. In a read, `sram_oe_n` must be low on samples 1 to `T_RD`, and `rd_valid` must appear on sample `T_RD + 1`. `req_ready` must then return after exactly `T_TURN` more samples. In a write, the phases must last `T_DS`, `T_WP`, `T_DH` and `T_GAP` samples in that order. For every access the bench counts these samples while it waits for `req_ready` and compares each count with its parameter. Read data is compared with a byte-masked scoreboard.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RD,
    S_TURN,
    S_WSU,
    S_WPW,
    S_WHD,
    S_GAP
  } seq_st_t;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DATA_W = 16,
  localparam int BE_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic [BE_W-1:0]   lane_sel,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  logic [DATA_W-1:0] lane_mask;

  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    assign lane_mask[g*8 +: 8] = {8{lane_sel[g]}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= cap_en;
      if (cap_en) rd_data <= dq_i & lane_mask;
    end
  end
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int T_RD   = 3,
  parameter int T_WP   = 3,
  parameter int T_DS   = 2,
  parameter int T_DH   = 1,
  parameter int T_TURN = 2,
  parameter int T_GAP  = 1,
  parameter int CNT_W  = 4,
  parameter int BE_W   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_we,
  input  logic [BE_W-1:0]  req_be,
  input  logic [CNT_W-1:0] cnt,
  output logic             cnt_clr,
  output logic             accept,
  output logic             cap_en,
  output logic [BE_W-1:0]  be_q,
  output logic             req_ready,
  output logic             ce_n,
  output logic             we_n,
  output logic             oe_n,
  output logic             ub_n,
  output logic             lb_n,
  output logic             dq_oe
);
  seq_st_t st, st_nx;
  logic    last;

  always_comb begin
    unique case (st)
      S_RD:    last = (cnt == CNT_W'(T_RD - 1));
      S_TURN:  last = (cnt == CNT_W'(T_TURN - 1));
      S_WSU:   last = (cnt == CNT_W'(T_DS - 1));
      S_WPW:   last = (cnt == CNT_W'(T_WP - 1));
      S_WHD:   last = (cnt == CNT_W'(T_DH - 1));
      S_GAP:   last = (cnt == CNT_W'(T_GAP - 1));
      default: last = 1'b0;
    endcase
  end

  assign accept = (st == S_IDLE) && req_ready && req_valid;
  assign cap_en = (st == S_RD) && last;

  always_comb begin
    st_nx = st;
    unique case (st)
      S_IDLE:  if (accept) st_nx = req_we ? S_WSU : S_RD;
      S_RD:    if (last) st_nx = S_TURN;
      S_TURN:  if (last) st_nx = S_IDLE;
      S_WSU:   if (last) st_nx = S_WPW;
      S_WPW:   if (last) st_nx = S_WHD;
      S_WHD:   if (last) st_nx = S_GAP;
      S_GAP:   if (last) st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  assign cnt_clr = (st_nx != st);

  logic [BE_W-1:0] be_nx;
  assign be_nx = accept ? req_be : be_q;

  // strobes are registered from the next state so they line up with st
  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      be_q      <= '0;
      req_ready <= 1'b0;
      ce_n      <= 1'b1;
      we_n      <= 1'b1;
      oe_n      <= 1'b1;
      ub_n      <= 1'b1;
      lb_n      <= 1'b1;
      dq_oe     <= 1'b0;
    end else begin
      st        <= st_nx;
      be_q      <= be_nx;
      req_ready <= (st_nx == S_IDLE);
      ce_n      <= !(st_nx inside {S_RD, S_WSU, S_WPW, S_WHD});
      we_n      <= (st_nx != S_WPW);
      oe_n      <= (st_nx != S_RD);
      dq_oe     <= (st_nx inside {S_WSU, S_WPW, S_WHD});
      ub_n      <= !((st_nx inside {S_RD, S_WSU, S_WPW, S_WHD}) && be_nx[1]);
      lb_n      <= !((st_nx inside {S_RD, S_WSU, S_WPW, S_WHD}) && be_nx[0]);
    end
  end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int T_RD   = 3,
  parameter int T_WP   = 3,
  parameter int T_DS   = 2,
  parameter int T_DH   = 1,
  parameter int T_TURN = 2,
  parameter int T_GAP  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic              sram_ub_n,
  output logic              sram_lb_n,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_i
);
  localparam int T_MAX = max_of(max_of(max_of(T_RD, T_WP), max_of(T_DS, T_DH)),
                                max_of(T_TURN, T_GAP));
  localparam int CNT_W = $clog2(T_MAX + 1) + 1;
  localparam int BE_W  = DATA_W / 8;

  logic [CNT_W-1:0] cnt;
  logic             cnt_clr, accept, cap_en;
  logic [BE_W-1:0]  be_q;

  sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .clr(cnt_clr), .cnt(cnt)
  );

  sram_seq_fsm #(
    .T_RD(T_RD), .T_WP(T_WP), .T_DS(T_DS), .T_DH(T_DH),
    .T_TURN(T_TURN), .T_GAP(T_GAP), .CNT_W(CNT_W), .BE_W(BE_W)
  ) u_fsm (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
    .req_be(req_be), .cnt(cnt), .cnt_clr(cnt_clr), .accept(accept),
    .cap_en(cap_en), .be_q(be_q), .req_ready(req_ready),
    .ce_n(sram_ce_n), .we_n(sram_we_n), .oe_n(sram_oe_n),
    .ub_n(sram_ub_n), .lb_n(sram_lb_n), .dq_oe(sram_dq_oe)
  );

  sram_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .cap_en(cap_en), .lane_sel(be_q),
    .dq_i(sram_dq_i), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // address and write data are latched once per access and held
  always_ff @(posedge clk) begin
    if (rst) begin
      sram_addr <= '0;
      sram_dq_o <= '0;
    end else if (accept) begin
      sram_addr <= req_addr;
      sram_dq_o <= req_wdata;
    end
  end
endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker #(
  parameter int ADDR_W = 18,
  parameter int T_WP   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_ce_n,
  input logic              sram_we_n,
  input logic              sram_oe_n,
  input logic              sram_ub_n,
  input logic              sram_lb_n,
  input logic              sram_dq_oe
);
  logic [15:0] wl_cnt;
  always_ff @(posedge clk) begin
    if (rst || sram_we_n) wl_cnt <= '0;
    else                  wl_cnt <= wl_cnt + 1'b1;
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (sram_ce_n && sram_we_n && sram_oe_n && sram_ub_n && sram_lb_n && !sram_dq_oe));
  a_r2_read_we_high: assert property (@(posedge clk) disable iff (rst)
    !sram_oe_n |-> (sram_we_n && !sram_ce_n));
  a_r4_no_contention: assert property (@(posedge clk) disable iff (rst)
    !(sram_dq_oe && !sram_oe_n));
  a_r5_we_in_ce: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> !sram_ce_n);
  a_r5_pulse_width: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_we_n) |-> (wl_cnt == 16'(T_WP)));
  a_r6_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (!sram_ce_n && !$past(sram_ce_n)) |-> $stable(sram_addr));
  a_r7_drive_in_pulse: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> sram_dq_oe);
  a_r7_setup_first: assert property (@(posedge clk) disable iff (rst)
    $fell(sram_we_n) |-> $past(sram_dq_oe));
  a_r8_we_gap: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_we_n) |=> sram_we_n);
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
endmodule

bind sram_async_ctrl sram_ctrl_checker #(.ADDR_W(ADDR_W), .T_WP(T_WP)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .rd_valid(rd_valid),
  .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
  .sram_oe_n(sram_oe_n), .sram_ub_n(sram_ub_n), .sram_lb_n(sram_lb_n),
  .sram_dq_oe(sram_dq_oe)
);

// File: tb/sim_sram_async_ctrl.sv
module sim_sram_async_ctrl;
  localparam int CLK_P = 10;
  localparam int T_RD = 3, T_WP = 3, T_DS = 2, T_DH = 1, T_TURN = 2, T_GAP = 1;

  logic        clk = 1'b0, rst = 1'b1;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [17:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rd_valid;
  logic [15:0] rd_data, sram_dq_o, sram_dq_i;
  logic [17:0] sram_addr;
  logic        sram_ce_n, sram_we_n, sram_oe_n, sram_ub_n, sram_lb_n, sram_dq_oe;

  int tests = 0, fails = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  sram_async_ctrl #(.T_RD(T_RD), .T_WP(T_WP), .T_DS(T_DS), .T_DH(T_DH),
                    .T_TURN(T_TURN), .T_GAP(T_GAP)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .sram_addr(sram_addr),
    .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
    .sram_ub_n(sram_ub_n), .sram_lb_n(sram_lb_n), .sram_dq_o(sram_dq_o),
    .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
  );

  // behavioural memory model, 64 words
  logic [15:0] mem [64];
  logic [15:0] sb  [64];
  logic        prev_we_n = 1'b1;

  assign sram_dq_i = (!sram_ce_n && !sram_oe_n && sram_we_n) ?
      {sram_ub_n ? 8'h00 : mem[sram_addr[5:0]][15:8],
       sram_lb_n ? 8'h00 : mem[sram_addr[5:0]][7:0]} : 16'h0000;

  always @(negedge clk) begin
    if (!prev_we_n && sram_we_n && !sram_ce_n && sram_dq_oe) begin
      if (!sram_ub_n) mem[sram_addr[5:0]][15:8] <= sram_dq_o[15:8];
      if (!sram_lb_n) mem[sram_addr[5:0]][7:0]  <= sram_dq_o[7:0];
    end
    prev_we_n <= sram_we_n;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] lane_mask(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  task automatic do_op(input bit we, input logic [17:0] addr, input logic [1:0] be,
                       input logic [15:0] data);
    int idx = 0, n_oe = 0, n_we = 0, n_ds = 0, n_dh = 0, n_tail = 0, rv_idx = 0, rv_cnt = 0;
    bit we_seen = 0, bad_addr = 0, bad_data = 0, bad_be = 0;
    logic [15:0] got = '0, exp;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = addr; req_be = be; req_wdata = data;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R12 ready low after accept", req_ready, 0);
    idx = 1;
    forever begin
      if (req_ready) break;
      if (!sram_oe_n) n_oe++;
      if (!sram_we_n) begin n_we++; we_seen = 1; end
      if (sram_dq_oe && sram_we_n && !we_seen) n_ds++;
      if (sram_dq_oe && sram_we_n && we_seen && !sram_ce_n) n_dh++;
      if (sram_ce_n) n_tail++;
      if (!sram_ce_n) begin
        if (sram_addr != addr) bad_addr = 1;
        if (sram_ub_n != !be[1] || sram_lb_n != !be[0]) bad_be = 1;
        if (sram_dq_oe && sram_dq_o != data) bad_data = 1;
      end
      if (rd_valid) begin rv_cnt++; if (rv_idx == 0) rv_idx = idx; got = rd_data; end
      @(negedge clk);
      idx++;
    end
    chk(!bad_addr, "R6 address held", int'(bad_addr), 0);
    chk(!bad_be, "R3 byte enables", int'(bad_be), 0);
    if (we) begin
      chk(n_we == T_WP, "R5 write pulse width", n_we, T_WP);
      chk(n_oe == 0, "R4 oe high in write", n_oe, 0);
      chk(n_ds == T_DS, "R7 data setup cycles", n_ds, T_DS);
      chk(n_dh == T_DH, "R7 data hold cycles", n_dh, T_DH);
      chk(!bad_data, "R7 write data", int'(bad_data), 0);
      chk(n_tail == T_GAP, "R8 recovery gap", n_tail, T_GAP);
      for (int b = 0; b < 2; b++)
        if (be[b]) sb[addr[5:0]][b*8 +: 8] = data[b*8 +: 8];
    end else begin
      exp = sb[addr[5:0]] & lane_mask(be);
      chk(n_oe == T_RD, "R2 read strobe cycles", n_oe, T_RD);
      chk(rv_idx == T_RD + 1, "R10 rd_valid timing", rv_idx, T_RD + 1);
      chk(rv_cnt == 1, "R10 rd_valid single", rv_cnt, 1);
      chk(got == exp, "R10 R11 read data", got, exp);
      chk(n_tail == T_TURN, "R9 turnaround idle", n_tail, T_TURN);
    end
    chk(sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe, "R1 standby when ready",
        {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe}, 4'b1110);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin mem[i] = '0; sb[i] = '0; end
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && sram_ce_n && sram_we_n && sram_oe_n && sram_ub_n && sram_lb_n
        && !sram_dq_oe && !rd_valid, "R1 reset state", req_ready, 1);
    // directed corners
    do_op(1, 18'h00005, 2'b11, 16'hA55A);
    do_op(0, 18'h00005, 2'b11, 16'h0000);
    do_op(1, 18'h00005, 2'b10, 16'h3C00);
    do_op(0, 18'h00005, 2'b11, 16'h0000);   // R11 lower lane kept
    do_op(1, 18'h3FFC5, 2'b01, 16'h00E7);   // top address bits
    do_op(0, 18'h3FFC5, 2'b10, 16'h0000);   // upper lane only
    do_op(0, 18'h00005, 2'b01, 16'h0000);   // lower lane only
    do_op(1, 18'h00010, 2'b11, 16'h1234);   // back-to-back writes
    do_op(1, 18'h00011, 2'b11, 16'hFEDC);
    do_op(0, 18'h00010, 2'b11, 16'h0000);   // read then write
    do_op(1, 18'h00012, 2'b11, 16'h0F0F);
    // random mix
    for (int n = 0; n < 60; n++) begin
      logic [1:0] be;
      bit w;
      w  = $urandom_range(0, 1) == 1;
      be = 2'($urandom_range(1, 3));
      do_op(w, 18'($urandom), be, 16'($urandom));
    end
    for (int a = 0; a < 8; a++) do_op(0, 18'(a), 2'b11, 16'h0000);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule